// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port. It is controlled through a simple synchronous register port. Each pin has its own output level, its own direction bit and its own interrupt trigger setting. The port drives pad output levels and output enables. It brings the pad inputs into the clock domain through a two-flop synchronizer. Software reads the pin state through the same register that holds the output levels.

For every pin, a small detector watches the synchronized input. It recognises a low level, a high level, a rising edge, a falling edge, or either edge. When the condition is seen, the detector sets that pin's status bit. Status bits are collected whether or not the pin is unmasked. Software clears them by writing ones. A single registered interrupt line goes high while any status bit is set on an unmasked pin.

The register port has no wait states. A write takes effect on the clock edge where it is presented. Read data comes out of a register one cycle after the address is presented. Register offsets: 0 output data, 1 direction, 2 trigger config for pins 0..15, 3 trigger config for pins 16..31, 4 interrupt enable, 5 status, 6 either-edge select, 7 write-only set, 8 write-only clear.

Top module: `gpio_irq_port`

## Requirements
- R1: Reset is synchronous and active high. After reset, every register is zero, and pin_out, pin_oe and irq are all 0.
- R2: A write to the direction register (offset 1) appears on pin_oe at the next clock edge. A 1 makes the pin an output and a 0 makes it an input. pin_out always shows the output data register (offset 0).
- R3: Writing the set register (offset 7) sets each output data bit where the write data is 1. Writing the clear register (offset 8) clears each such bit. Bits written as 0 keep their value in both cases. Both registers read as 0.
- R4: Reading offset 0 returns, for each pin, the output data bit when the pin is an output and the synchronized input when it is an input. bus_rdata shows the addressed register one cycle after the address is presented.
- R5: Each pin's 2-bit trigger field sits at bits 2p+1:2p. For pin p below 16 the field is in config word 2. For pin p of 16 or above it is in config word 3, at position p-16.
- R6: Trigger code 00 detects a low level and code 01 detects a high level. While the level lasts, the status bit sets again right after it is cleared.
- R7: Trigger code 10 detects a rising edge of the synchronized input and code 11 a falling edge. The opposite transition, and a steady level, set nothing.
- R8: When a pin's either-edge bit (offset 6) is 1, both transitions set its status bit and its 2-bit field is ignored.
- R9: Status bits (offset 5) latch regardless of the mask. Writing a 1 clears a bit. Writing a 0 leaves it unchanged. If a detection and a clear fall in the same cycle, the detection wins.
- R10: irq is the registered OR, over all pins, of status AND interrupt enable (offset 4). Enable bits are 1 for unmasked.
- R11: A pin change presented before clock edge 1 sets the status bit at edge 3: two edges for the synchronizer and one edge for the detector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed delay after its stimulus:
- A register write shows on pin_out or pin_oe at the edge that takes it.
- A read returns data at the edge after the address is presented.
- A pad change reaches the status register at the third edge.
- irq follows status and enable one edge later.

The bench drives stimulus on falling edges and samples shortly after rising edges. To check the synchronizer depth, it reads status at the third edge after a pin change, expecting the old value, and again at the fourth edge, expecting the new bit. Every other status check waits four edges after the stimulus, so a one-cycle slip in the detect path still changes a checked value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_ANY    = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_SET    = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 4'd8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
(
  input  logic       cur_i,
  input  logic       prev_i,
  input  logic [1:0] mode_i,
  input  logic       any_edge_i,
  output logic       hit_o
);
  logic rise, fall;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    if (any_edge_i) begin
      hit_o = rise | fall;
    end else begin
      unique case (trig_e'(mode_i))
        TRIG_LOW:  hit_o = ~cur_i;
        TRIG_HIGH: hit_o = cur_i;
        TRIG_RISE: hit_o = rise;
        TRIG_FALL: hit_o = fall;
        default:   hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] data_q, dir_q, mask_q, status_q, any_q;
  logic [NPINS-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPINS-1:0] sync_w, prev_q, hit_w;
  logic [NPINS-1:0] rdata_q;
  logic             irq_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_in),
    .sync_o  (sync_w)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_w;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = cfg_lo_q[2*p +: 2];
    end else begin : g_hi
      assign mode = cfg_hi_q[2*(p-HALF) +: 2];
    end
    gpio_trig_detect u_det (
      .cur_i      (sync_w[p]),
      .prev_i     (prev_q[p]),
      .mode_i     (mode),
      .any_edge_i (any_q[p]),
      .hit_o      (hit_w[p])
    );
  end

  logic wr_data, wr_dir, wr_lo, wr_hi, wr_mask, wr_stat, wr_any, wr_set, wr_clr;
  assign wr_data = bus_we && bus_addr == OFS_DATA;
  assign wr_dir  = bus_we && bus_addr == OFS_DIR;
  assign wr_lo   = bus_we && bus_addr == OFS_CFG_LO;
  assign wr_hi   = bus_we && bus_addr == OFS_CFG_HI;
  assign wr_mask = bus_we && bus_addr == OFS_MASK;
  assign wr_stat = bus_we && bus_addr == OFS_STAT;
  assign wr_any  = bus_we && bus_addr == OFS_ANY;
  assign wr_set  = bus_we && bus_addr == OFS_SET;
  assign wr_clr  = bus_we && bus_addr == OFS_CLR;

  logic [NPINS-1:0] data_nxt, stat_clr;
  always_comb begin
    data_nxt = data_q;
    if (wr_data) data_nxt = bus_wdata;
    if (wr_set)  data_nxt = data_q | bus_wdata;
    if (wr_clr)  data_nxt = data_q & ~bus_wdata;
  end
  assign stat_clr = wr_stat ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      any_q    <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      data_q   <= data_nxt;
      if (wr_dir)  dir_q    <= bus_wdata;
      if (wr_lo)   cfg_lo_q <= bus_wdata;
      if (wr_hi)   cfg_hi_q <= bus_wdata;
      if (wr_mask) mask_q   <= bus_wdata;
      if (wr_any)  any_q    <= bus_wdata;
      status_q <= (status_q & ~stat_clr) | hit_w;
      irq_q    <= |(status_q & mask_q);
    end
  end

  logic [NPINS-1:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      OFS_DATA:   rd_mux = (data_q & dir_q) | (sync_w & ~dir_q);
      OFS_DIR:    rd_mux = dir_q;
      OFS_CFG_LO: rd_mux = cfg_lo_q;
      OFS_CFG_HI: rd_mux = cfg_hi_q;
      OFS_MASK:   rd_mux = mask_q;
      OFS_STAT:   rd_mux = status_q;
      OFS_ANY:    rd_mux = any_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = data_q;
  assign pin_oe    = dir_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  mask_q
);
  // R1
  reset_clean_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !irq));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata));

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  // R3
  clr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_CLR) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == OFS_STAT) |=> (status_q & $past(status_q)) == $past(status_q));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) != '0) |=> irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |=> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  import gpio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #2;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic clear_all();
    wr(OFS_STAT, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #2;
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(OFS_MASK, v);
    chk("R1 mask", v, 32'h0);
    rd(OFS_CFG_LO, v);
    chk("R1 cfg_lo", v, 32'h0);
  endtask

  task automatic t_dir_data();
    logic [31:0] v;
    pin_in = 32'h0000_5A5A;
    wr(OFS_DIR, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    wr(OFS_DATA, 32'hA5A5_1234);
    chk("R2 pin_out", pin_out, 32'hA5A5_1234);
    rd(OFS_DATA, v);
    chk("R4 data readback", v, 32'hA5A5_5A5A);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(OFS_SET, 32'h0000_00F0);
    chk("R3 set", pin_out, 32'hA5A5_12F4);
    wr(OFS_CLR, 32'hA500_0000);
    chk("R3 clear", pin_out, 32'h00A5_12F4);
    rd(OFS_SET, v);
    chk("R3 set reads zero", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pin_in = 32'h0;
    wr(OFS_CFG_LO, 32'hAAAA_AA6A);
    wr(OFS_CFG_HI, 32'hAAAA_A8AA);
    clear_all();
    rd(OFS_STAT, v);
    chk("R5 R6 low level pin 20", v, 32'h0010_0000);
    pin_in = 32'h0010_0008;
    settle();
    rd(OFS_STAT, v);
    chk("R6 high level pin 3", v, 32'h0010_0008);
    clear_all();
    rd(OFS_STAT, v);
    chk("R6 level re-sets", v, 32'h0000_0008);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(OFS_CFG_LO, 32'hAAAA_AEAA);
    wr(OFS_CFG_HI, 32'hAAAA_AAAA);
    clear_all();
    pin_in = pin_in | 32'h0000_0021;
    settle();
    rd(OFS_STAT, v);
    chk("R7 rise pin 0 only", v, 32'h0000_0001);
    clear_all();
    rd(OFS_STAT, v);
    chk("R7 steady level sets nothing", v, 32'h0);
    pin_in = pin_in & ~32'h0000_0021;
    settle();
    rd(OFS_STAT, v);
    chk("R7 fall pin 5 only", v, 32'h0000_0020);
    clear_all();
  endtask

  task automatic t_latency();
    logic [31:0] v;
    @(negedge clk);
    pin_in = pin_in | 32'h0000_0002;
    @(posedge clk);
    @(posedge clk);
    rd(OFS_STAT, v);
    chk("R11 not yet at edge 3", v, 32'h0);
    rd(OFS_STAT, v);
    chk("R11 set at edge 3", v, 32'h0000_0002);
    clear_all();
  endtask

  task automatic t_anyedge();
    logic [31:0] v;
    wr(OFS_ANY, 32'h0000_0080);
    pin_in = pin_in | 32'h0000_0080;
    settle();
    rd(OFS_STAT, v);
    chk("R8 either edge rise", v, 32'h0000_0080);
    clear_all();
    pin_in = pin_in & ~32'h0000_0080;
    settle();
    rd(OFS_STAT, v);
    chk("R8 either edge fall", v, 32'h0000_0080);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    #1;
    chk("R10 masked no irq", {31'h0, irq}, 32'h0);
    wr(OFS_MASK, 32'h0000_0080);
    @(posedge clk);
    #2;
    chk("R10 unmasked irq", {31'h0, irq}, 32'h1);
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, v);
    chk("R9 write zero keeps status", v, 32'h0000_0080);
    wr(OFS_STAT, 32'h0000_0080);
    @(posedge clk);
    #2;
    chk("R9 R10 clear drops irq", {31'h0, irq}, 32'h0);
    rd(OFS_STAT, v);
    chk("R9 cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_dir_data();
    t_setclr();
    t_level();
    t_edge();
    t_latency();
    t_anyedge();
    t_mask();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule